// File: doc/BRIEF.md
# Hierarchical Tiled Subtile Address Generator

This block turns a position in a tiled texture image into a byte address. The caller gives a microtile column, a microtile row and the image width counted in microtiles. The block returns the byte offset of the subtile that holds that microtile. Each microtile is 64 bytes. A subtile is a 4x4 group of microtiles in raster order, which makes 1 KB. Four subtiles form a 4 KB tile. The tiles fill the image row by row, and the direction of travel reverses on every row of tiles. The order of the four subtiles inside a tile also depends on whether the tile row is even or odd.

The datapath has two register stages. A request accepted on `in_valid` appears on `out_valid` two clock edges later. The block checks the alignment rules and reports any breach on a flag that travels with the address; the address is still produced. A build-time switch can also add the offset of the microtile inside its subtile. This lets the same block address single microtiles as well as whole subtiles.

Top module: `tiled_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `out_addr` and `out_align_err` are all 0.
- R2: A request presented with `in_valid` high at one rising edge gives its result, with `out_valid` high, after the second rising edge that follows. Requests may be presented on every cycle, and each one gets its own result.
- R3: The tile column is the microtile x divided by 8, the tile row is the microtile y divided by 8, and the tiles per row is the width divided by 8. The address contains the term 4096 * (tile row * tiles per row + tile column).
- R4: On an odd tile row, the tile column used in R3 is replaced by (tiles per row - 1 - tile column).
- R5: The subtile index is 2 * bit 2 of y plus bit 2 of x. On an even tile row, indices 0, 1, 2 and 3 select slots 0, 3, 1 and 2. The address adds 1024 * slot.
- R6: On an odd tile row, indices 0, 1, 2 and 3 select slots 2, 1, 3 and 0.
- R7: If the width is not a multiple of 8, `out_align_err` is 1 for that result, and the address is still computed from the width divided by 8, rounded down.
- R8: With `FINE_EN` = 0, an x or y that is not a multiple of 4 sets `out_align_err`. The low two bits of that coordinate are then ignored.
- R9: With `FINE_EN` = 1, the address also adds 64 * (4 * (y mod 4) + (x mod 4)), and unaligned coordinates do not set `out_align_err`.
- R10: When no result is delivered (`out_valid` low after reset), `out_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mt_x | input | COORD_W | Microtile column |
| mt_y | input | COORD_W | Microtile row |
| row_mt | input | COORD_W | Image width in microtiles |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_addr | output | ADDR_W | Byte address of the subtile (or microtile when FINE_EN=1) |
| out_align_err | output | 1 | Alignment rule broken for this result |

## Verification
The bench builds two copies side by side with COORD_W=12 and ADDR_W=32. One has FINE_EN=0 and the other FINE_EN=1, and both get the same stimulus. An unaligned coordinate therefore shows both readings at once: the subtile copy flags it and ignores the low bits, while the microtile copy adds the offset with no error. An image 4 tiles wide brings the reversed column on odd rows and every even and odd subtile slot within reach. Bursts of back-to-back requests confirm that each result leaves the pipeline in its own slot.

// File: rtl/tiled_addr_pkg.sv
package tiled_addr_pkg;
    localparam int MT_SHIFT      = 6;   // 64-byte microtile
    localparam int SUBTILE_SHIFT = 10;  // 1 KB subtile
    localparam int TILE_SHIFT    = 12;  // 4 KB tile
    localparam int TILE_MT_LOG2  = 3;   // 8 microtiles across a tile

    typedef logic [1:0] slot_t;
endpackage

// File: rtl/tiled_tile_locator.sv
module tiled_tile_locator #(
    parameter int TW = 9
) (
    input  logic [TW-1:0] x_hi,
    input  logic [TW-1:0] y_hi,
    input  logic [TW-1:0] tpr,
    output logic [TW-1:0] col_adj,
    output logic          odd_row
);
    always_comb begin
        odd_row = y_hi[0];
        if (odd_row) begin
            col_adj = tpr - x_hi - TW'(1);
        end else begin
            col_adj = x_hi;
        end
    end
endmodule

// File: rtl/tiled_subtile_map.sv
module tiled_subtile_map
    import tiled_addr_pkg::*;
(
    input  logic [1:0] idx,
    input  logic       odd_row,
    output slot_t      slot
);
    always_comb begin
        if (odd_row) begin
            unique case (idx)
                2'd0:    slot = 2'd2;
                2'd1:    slot = 2'd1;
                2'd2:    slot = 2'd3;
                default: slot = 2'd0;
            endcase
        end else begin
            unique case (idx)
                2'd0:    slot = 2'd0;
                2'd1:    slot = 2'd3;
                2'd2:    slot = 2'd1;
                default: slot = 2'd2;
            endcase
        end
    end
endmodule

// File: rtl/tiled_align_check.sv
module tiled_align_check #(
    parameter bit CHECK_COORDS = 1'b1
) (
    input  logic [1:0] x_lo,
    input  logic [1:0] y_lo,
    input  logic [2:0] stride_lo,
    output logic       err
);
    logic stride_bad;
    assign stride_bad = |stride_lo;

    generate
        if (CHECK_COORDS) begin : g_coord
            assign err = stride_bad | (|x_lo) | (|y_lo);
        end else begin : g_stride_only
            logic unused_lo;
            assign unused_lo = ^{x_lo, y_lo};
            assign err = stride_bad;
        end
    endgenerate
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen
    import tiled_addr_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 32,
    parameter bit FINE_EN = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] mt_x,
    input  logic [COORD_W-1:0] mt_y,
    input  logic [COORD_W-1:0] row_mt,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_align_err
);
    localparam int TW = COORD_W - TILE_MT_LOG2;

    typedef struct packed {
        logic          vld;
        logic          err;
        slot_t         slot;
        logic [3:0]    fine;
        logic [TW-1:0] col;
        logic [TW-1:0] row;
        logic [TW-1:0] tpr;
    } stage1_t;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } state_t;

    state_t state_d, state_q;

    logic [TW-1:0] col_adj;
    logic          odd_row;
    slot_t         slot;
    logic          align_err;
    logic [3:0]    fine_idx;

    tiled_tile_locator #(.TW(TW)) u_loc (
        .x_hi    (mt_x[COORD_W-1:TILE_MT_LOG2]),
        .y_hi    (mt_y[COORD_W-1:TILE_MT_LOG2]),
        .tpr     (row_mt[COORD_W-1:TILE_MT_LOG2]),
        .col_adj (col_adj),
        .odd_row (odd_row)
    );

    tiled_subtile_map u_map (
        .idx     ({mt_y[2], mt_x[2]}),
        .odd_row (odd_row),
        .slot    (slot)
    );

    tiled_align_check #(.CHECK_COORDS(!FINE_EN)) u_chk_align (
        .x_lo      (mt_x[1:0]),
        .y_lo      (mt_y[1:0]),
        .stride_lo (row_mt[2:0]),
        .err       (align_err)
    );

    generate
        if (FINE_EN) begin : g_fine
            assign fine_idx = {mt_y[1:0], mt_x[1:0]};
        end else begin : g_coarse
            assign fine_idx = 4'd0;
        end
    endgenerate

    always_comb begin
        state_d = state_q;

        state_d.s1.vld = in_valid;
        if (in_valid) begin
            state_d.s1.err  = align_err;
            state_d.s1.slot = slot;
            state_d.s1.fine = fine_idx;
            state_d.s1.col  = col_adj;
            state_d.s1.row  = mt_y[COORD_W-1:TILE_MT_LOG2];
            state_d.s1.tpr  = row_mt[COORD_W-1:TILE_MT_LOG2];
        end

        state_d.s2.vld = state_q.s1.vld;
        if (state_q.s1.vld) begin
            state_d.s2.err  = state_q.s1.err;
            state_d.s2.addr =
                ((ADDR_W'(state_q.s1.row) * ADDR_W'(state_q.s1.tpr)
                  + ADDR_W'(state_q.s1.col)) << TILE_SHIFT)
                + (ADDR_W'(state_q.s1.slot) << SUBTILE_SHIFT)
                + (ADDR_W'(state_q.s1.fine) << MT_SHIFT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid     = state_q.s2.vld;
    assign out_addr      = state_q.s2.addr;
    assign out_align_err = state_q.s2.err;
endmodule

// File: rtl/tiled_addr_chk.sv
module tiled_addr_chk #(
    parameter int ADDR_W  = 32,
    parameter bit FINE_EN = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        x_lo,
    input logic [1:0]        y_lo,
    input logic [2:0]        stride_lo,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_align_err
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_addr == '0 && !out_align_err));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R7
    stride_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stride_lo != 3'd0) |-> ##2 out_align_err);

    // R8
    coord_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!FINE_EN && in_valid && (x_lo != 2'd0 || y_lo != 2'd0)) |-> ##2 out_align_err);

    // R9
    fine_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (FINE_EN && in_valid && stride_lo == 3'd0) |-> ##2 !out_align_err);

    // R5
    granule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr[5:0] == 6'd0);

    // R10
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_addr));
endmodule

bind tiled_addr_gen tiled_addr_chk #(.ADDR_W(ADDR_W), .FINE_EN(FINE_EN)) u_addr_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .x_lo          (mt_x[1:0]),
    .y_lo          (mt_y[1:0]),
    .stride_lo     (row_mt[2:0]),
    .out_valid     (out_valid),
    .out_addr      (out_addr),
    .out_align_err (out_align_err)
);

// File: tb/tiled_addr_gen_test.sv
module tiled_addr_gen_test;
    localparam int CW = 12;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [CW-1:0] mt_x = '0;
    logic [CW-1:0] mt_y = '0;
    logic [CW-1:0] row_mt = '0;
    logic          v_c, v_f, e_c, e_f;
    logic [AW-1:0] a_c, a_f;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tiled_addr_gen #(.COORD_W(CW), .ADDR_W(AW), .FINE_EN(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .mt_x(mt_x), .mt_y(mt_y), .row_mt(row_mt),
        .out_valid(v_c), .out_addr(a_c), .out_align_err(e_c));

    tiled_addr_gen #(.COORD_W(CW), .ADDR_W(AW), .FINE_EN(1'b1)) uut_fine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .mt_x(mt_x), .mt_y(mt_y), .row_mt(row_mt),
        .out_valid(v_f), .out_addr(a_f), .out_align_err(e_f));

    function automatic int slot_of(int idx, bit odd);
        int s;
        if (odd) s = (idx == 0) ? 2 : (idx == 1) ? 1 : (idx == 2) ? 3 : 0;
        else     s = (idx == 0) ? 0 : (idx == 1) ? 3 : (idx == 2) ? 1 : 2;
        return s;
    endfunction

    function automatic int model_addr(int x, int y, int w, bit fine);
        int tpr, col, row, idx, a;
        bit odd;
        tpr = w / 8;
        col = x / 8;
        row = y / 8;
        odd = row[0];
        if (odd) col = tpr - 1 - col;
        idx = ((y / 4) % 2) * 2 + ((x / 4) % 2);
        a = 4096 * (row * tpr + col) + 1024 * slot_of(idx, odd);
        if (fine) a = a + 64 * ((y % 4) * 4 + (x % 4));
        return a;
    endfunction

    task automatic check(string req, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic check_result(string req, int x, int y, int w);
        bit ew, ec;
        ew = (w % 8) != 0;
        ec = ((x % 4) != 0) || ((y % 4) != 0);
        check(req, "valid", v_c, 1);
        check(req, "addr", a_c, model_addr(x, y, w, 1'b0));
        check(req, "err", e_c, ew || ec);
        check(req, "fine valid", v_f, 1);
        check(req, "fine addr", a_f, model_addr(x, y, w, 1'b1));
        check(req, "fine err", e_f, ew);
    endtask

    task automatic one_req(string req, int x, int y, int w);
        @(negedge clk);
        in_valid = 1'b1; mt_x = CW'(x); mt_y = CW'(y); row_mt = CW'(w);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_result(req, x, y, w);
    endtask

    task automatic test_reset();
        check("R1", "valid in reset", v_c, 0);
        check("R1", "addr in reset", a_c, 0);
        check("R1", "err in reset", e_f, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after reset", v_c, 0);
        check("R1", "addr after reset", a_f, 0);
    endtask

    task automatic test_even_tiles();
        one_req("R3", 0, 0, 32);
        one_req("R3", 8, 0, 32);
        one_req("R3", 24, 0, 32);
        one_req("R3", 16, 16, 32);
    endtask

    task automatic test_even_slots();
        one_req("R5", 4, 0, 32);
        one_req("R5", 0, 4, 32);
        one_req("R5", 4, 4, 32);
        check("R5", "slot2 addr", a_c, 2048);
    endtask

    task automatic test_odd_rows();
        one_req("R4", 0, 8, 32);
        check("R4", "reversed col", a_c, 30720);
        one_req("R4", 24, 8, 32);
        one_req("R6", 4, 8, 32);
        one_req("R6", 0, 12, 32);
        one_req("R6", 4, 12, 32);
        one_req("R6", 12, 28, 32);
    endtask

    task automatic test_stride_err();
        one_req("R7", 8, 8, 36);
        one_req("R7", 0, 0, 33);
    endtask

    task automatic test_coord_err();
        one_req("R8", 2, 0, 32);
        one_req("R8", 4, 7, 32);
    endtask

    task automatic test_fine();
        one_req("R9", 5, 6, 32);
        check("R9", "fine offset", a_f, 2624);
        one_req("R9", 11, 9, 32);
    endtask

    task automatic test_hold();
        logic [AW-1:0] last;
        one_req("R10", 20, 4, 32);
        last = a_c;
        repeat (3) @(negedge clk);
        check("R10", "valid idle", v_c, 0);
        check("R10", "addr held", a_c, last);
    endtask

    task automatic test_stream();
        @(negedge clk);
        in_valid = 1'b1; mt_x = 4; mt_y = 8; row_mt = 32;
        @(negedge clk);
        mt_x = 16; mt_y = 0; row_mt = 32;
        @(negedge clk);
        check_result("R2", 4, 8, 32);
        mt_x = 8; mt_y = 12; row_mt = 40;
        @(negedge clk);
        in_valid = 1'b0;
        check_result("R2", 16, 0, 32);
        @(negedge clk);
        check_result("R2", 8, 12, 40);
        @(negedge clk);
        check("R2", "valid drops", v_c, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_even_tiles();
        test_even_slots();
        test_odd_rows();
        test_stride_err();
        test_coord_err();
        test_fine();
        test_hold();
        test_stream();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule